// File: doc/BRIEF.md
# Accumulator Stored-Program Processor

A small processor that runs programs held in one memory shared by code and data. It keeps a program counter, an instruction register, a single accumulator and three comparison flags (greater, equal, less). Each instruction goes through a fixed sequence of steps. The word at the program counter is fetched and latched, and the counter moves on to the next word. The opcode is then decoded. If the instruction needs a memory operand, that operand is read. The instruction is executed, or its store is written back, and control returns to fetch.

The block connects to a synchronous single-port memory through an address, write data, write enable and read data. Read data appears one clock after the address is presented. Programs are placed in memory while reset is held low. After reset, execution starts at address 10. A halt instruction stops fetching, and the processor stays stopped until the next reset.

Instruction word: bits 15:12 hold the opcode and bits 11:0 hold the address field. The opcodes are LOAD=1, STORE=2, ADD=3, SUB=4, AND=5, OR=6, CLEAR=7, JUMP=8, COMPARE=9, JEQ=10, JGT=11, JLT=12 and HALT=15.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low and on the first cycle after it, the outputs are halted=0, acc=0, flags=0 and mem_we=0, and mem_addr presents 10, the first fetch address.
- R2: LOAD sets acc to mem[A]. ADD sets acc to acc+mem[A] and SUB sets acc to acc-mem[A], both wrapping modulo 2^16.
- R3: AND and OR combine acc bitwise with mem[A] and place the result in acc.
- R4: STORE writes acc to address A and CLEAR writes 0 to address A. Each of them raises mem_we for exactly one cycle. No other instruction writes memory.
- R5: flags[2]=GT, flags[1]=EQ and flags[0]=LT. COMPARE sets exactly one of them by comparing acc with mem[A] as signed 16-bit values. All other instructions leave the flags unchanged.
- R6: JUMP loads the program counter from A.
- R7: JEQ, JGT and JLT load the program counter from A only when EQ, GT or LT respectively is set. Otherwise execution continues at the next word.
- R8: HALT raises halted. Once halted, the block performs no memory writes, keeps mem_addr and acc constant, and holds these values until reset.
- R9: Instructions with a memory operand (LOAD, ADD, SUB, AND, OR, COMPARE) take 4 cycles. STORE, CLEAR and all jumps take 3 cycles. HALT raises halted 2 cycles after its fetch begins.
- R10: Opcodes 0, 13 and 14 act as no-ops that take 2 cycles and change no state except the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| acc | output | 16 | Accumulator value |
| flags | output | 3 | {GT, EQ, LT} comparison flags |
| halted | output | 1 | High once a HALT has executed |

## Verification
The assertions assume that rst_n is low from time zero and that the memory answers every address with read data exactly one cycle later. The bench's memory model therefore registers its read port, and reset is held low while each program is loaded. All bench programs stay within the low 256 words, so the model memory covers every address the processor can issue. Every program ends in HALT, which means the checks on the halted state are exercised in every run.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DW       = 16,
  parameter int AW       = 12,
  parameter int RESET_PC = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc,
  output logic [2:0]    flags,
  output logic          halted
);
  localparam int OPW = DW - AW;
  localparam logic [OPW-1:0] OP_LOAD = 1, OP_STORE = 2, OP_ADD = 3, OP_SUB = 4,
    OP_AND = 5, OP_OR = 6, OP_CLEAR = 7, OP_JMP = 8, OP_CMP = 9,
    OP_JEQ = 10, OP_JGT = 11, OP_JLT = 12, OP_HALT = 15;

  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_OPRD, S_EXEC, S_WB, S_HALT} state_t;

  state_t          state;
  logic [AW-1:0]   pc;
  logic [DW-1:0]   ir;
  logic [DW-1:0]   acc_q;
  logic [2:0]      flg_q;

  wire [OPW-1:0] new_op = mem_rdata[DW-1 -: OPW];
  wire [OPW-1:0] ir_op  = ir[DW-1 -: OPW];
  wire [AW-1:0]  ir_adr = ir[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= AW'(RESET_PC);
      ir    <= '0;
      acc_q <= '0;
      flg_q <= '0;
    end else begin
      case (state)
        S_FETCH: state <= S_DECODE;
        S_DECODE: begin
          ir <= mem_rdata;
          pc <= pc + 1'b1;
          case (new_op)
            OP_LOAD, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_CMP: state <= S_OPRD;
            OP_STORE, OP_CLEAR:                           state <= S_WB;
            OP_JMP, OP_JEQ, OP_JGT, OP_JLT:               state <= S_EXEC;
            OP_HALT:                                      state <= S_HALT;
            default:                                      state <= S_FETCH;
          endcase
        end
        S_OPRD: state <= S_EXEC;
        S_EXEC: begin
          state <= S_FETCH;
          case (ir_op)
            OP_LOAD: acc_q <= mem_rdata;
            OP_ADD:  acc_q <= acc_q + mem_rdata;
            OP_SUB:  acc_q <= acc_q - mem_rdata;
            OP_AND:  acc_q <= acc_q & mem_rdata;
            OP_OR:   acc_q <= acc_q | mem_rdata;
            OP_CMP: begin
              if ($signed(acc_q) > $signed(mem_rdata))       flg_q <= 3'b100;
              else if (acc_q == mem_rdata)                   flg_q <= 3'b010;
              else                                           flg_q <= 3'b001;
            end
            OP_JMP: pc <= ir_adr;
            OP_JEQ: if (flg_q[1]) pc <= ir_adr;
            OP_JGT: if (flg_q[2]) pc <= ir_adr;
            OP_JLT: if (flg_q[0]) pc <= ir_adr;
            default: ;
          endcase
        end
        S_WB:    state <= S_FETCH;
        S_HALT:  state <= S_HALT;
        default: state <= S_FETCH;
      endcase
    end
  end

  assign mem_addr  = (state == S_FETCH) ? pc : ir_adr;
  assign mem_we    = (state == S_WB);
  assign mem_wdata = (ir_op == OP_STORE) ? acc_q : '0;
  assign acc       = acc_q;
  assign flags     = flg_q;
  assign halted    = (state == S_HALT);
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DW       = 16,
  parameter int AW       = 12,
  parameter int RESET_PC = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic [DW-1:0] acc,
  input logic [2:0]    flags,
  input logic          halted
);
  // R1
  first_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mem_addr == AW'(RESET_PC) && !mem_we && !halted));
  // R4
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R5
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags));
  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !mem_we && $stable(mem_addr) && $stable(acc) && $stable(flags));
  // R8
  halt_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);
endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW), .AW(AW), .RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
  .acc(acc), .flags(flags), .halted(halted)
);

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we;
  logic [15:0] acc;
  logic [2:0]  flags;
  logic        halted;

  always #4 clk = ~clk;

  acc_cpu u0 (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .acc(acc), .flags(flags), .halted(halted));

  logic [15:0] mem [256];
  logic        ld_en = 0;
  logic [7:0]  ld_addr = 0;
  logic [15:0] ld_data = 0;
  int          wr_cnt = 0;

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
    if (rst_n && mem_we) wr_cnt <= wr_cnt + 1;
  end

  int total = 0, bad = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(int op, int a);
    return {op[3:0], a[11:0]};
  endfunction

  task automatic put(int a, logic [15:0] v);
    ld_addr = a[7:0]; ld_data = v; ld_en = 1;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic begin_load();
    rst_n = 0;
    @(negedge clk);
    for (int i = 0; i < 256; i++) put(i, 16'h0000);
  endtask

  task automatic run(output int cyc);
    @(negedge clk);
    rst_n = 1;
    cyc = 0;
    for (int k = 0; k < 400; k++) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (halted) break;
    end
    if (!halted) check("watchdog run", 0, 1);
  endtask

  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] a, b, res;
    logic [2:0]  fl;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{4'd1, 16'h1234, 16'h00AA, 16'h00AA, 3'b000},  // R2 load
    '{4'd3, 16'd7,    16'd4,    16'd11,   3'b000},  // R2 add
    '{4'd3, 16'hFFFF, 16'd1,    16'h0000, 3'b000},  // R2 add wrap
    '{4'd4, 16'd4,    16'd7,    16'hFFFD, 3'b000},  // R2 sub wrap
    '{4'd5, 16'hF0F0, 16'h0FF0, 16'h00F0, 3'b000},  // R3 and
    '{4'd6, 16'hF000, 16'h000F, 16'hF00F, 3'b000},  // R3 or
    '{4'd9, 16'd5,    16'd3,    16'd5,    3'b100},  // R5 gt
    '{4'd9, 16'hFFFF, 16'd1,    16'hFFFF, 3'b001},  // R5 signed lt
    '{4'd9, 16'd9,    16'd9,    16'd9,    3'b010},  // R5 eq
    '{4'd9, 16'h7FFF, 16'h8000, 16'h7FFF, 3'b100}   // R5 signed gt
  };

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'd5, 4'd6: return "R3";
      4'd9:       return "R5";
      default:    return "R2";
    endcase
  endfunction

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc, w0;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 halted", halted, 0);
    check("R1 acc", acc, 0);
    check("R1 flags", flags, 0);
    check("R1 we", mem_we, 0);
    check("R1 addr", mem_addr, 10);

    foreach (VEC[i]) begin
      begin_load();
      put(10, ins(1, 100));
      put(11, ins(VEC[i].op, 101));
      put(12, ins(15, 0));
      put(100, VEC[i].a);
      put(101, VEC[i].b);
      run(cyc);
      check({tag_of(VEC[i].op), " acc"}, acc, VEC[i].res);
      check({tag_of(VEC[i].op), " flags"}, flags, VEC[i].fl);
      check("R9 cycles", cyc, 10);
    end

    // Reference program: R4 R6 R9
    begin_load();
    put(10, ins(1, 20)); put(11, ins(3, 21)); put(12, ins(2, 22));
    put(13, ins(8, 16)); put(14, ins(4, 20)); put(15, ins(7, 20));
    put(16, ins(7, 23)); put(17, ins(15, 0));
    put(20, 7); put(21, 4); put(22, 0); put(23, 16'h0055);
    w0 = wr_cnt;
    run(cyc);
    check("R2 ref acc", acc, 11);
    check("R4 store", mem[22], 11);
    check("R4 clear", mem[23], 0);
    check("R6 skipped", mem[20], 7);
    check("R4 writes", wr_cnt - w0, 2);
    check("R9 ref cycles", cyc, 19);

    // R8 halt holds
    w0 = wr_cnt;
    repeat (20) @(negedge clk);
    check("R8 halted", halted, 1);
    check("R8 acc", acc, 11);
    check("R8 nowrite", wr_cnt - w0, 0);

    // R7 conditional jumps, R5 flags kept through LOAD/ADD
    begin_load();
    put(10, ins(1, 100)); put(11, ins(9, 101)); put(12, ins(10, 30));
    put(13, ins(12, 30)); put(14, ins(11, 40));
    put(30, ins(1, 102)); put(31, ins(15, 0));
    put(40, ins(1, 103)); put(41, ins(3, 104)); put(42, ins(15, 0));
    put(100, 5); put(101, 3); put(102, 16'h0BAD); put(103, 16'h600D); put(104, 1);
    run(cyc);
    check("R7 acc", acc, 16'h600E);
    check("R5 flags kept", flags, 3'b100);
    check("R7 cycles", cyc, 4 + 4 + 3 + 3 + 3 + 4 + 4 + 2);

    // R10 unknown opcode is a no-op
    begin_load();
    put(10, ins(1, 100)); put(11, ins(13, 100)); put(12, ins(0, 100));
    put(13, ins(15, 0)); put(100, 16'h4321);
    w0 = wr_cnt;
    run(cyc);
    check("R10 acc", acc, 16'h4321);
    check("R10 writes", wr_cnt - w0, 0);
    check("R10 cycles", cyc, 4 + 2 + 2 + 2);
    check("R10 mem", mem[100], 16'h4321);

    // R1 reset clears a halted machine
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    check("R1 rehalt", halted, 0);
    check("R1 reacc", acc, 0);
    check("R1 readdr", mem_addr, 10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule